// File: doc/BRIEF.md
# Disk Block Address Calculator

This block turns the contents of a disk task file into a linear byte offset on the selected drive. A request carries four register bytes: the drive/head byte, the high and low cylinder bytes, and the sector byte. One bit of the drive/head byte chooses the addressing mode. In linear block mode the four bytes are packed into a 28-bit block number. In cylinder/head/sector mode the block number is computed from the geometry of the addressed drive. In both modes the block number is then multiplied by the drive's block size. Each of the two drives has its own geometry on static configuration inputs: head count, sectors per track and bytes per block.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the register bytes are sampled on that edge. A source holding `req_valid` while `req_ready` is low is not served and loses nothing; it simply waits. The result side has no back-pressure: `res_valid` is a single-cycle pulse, and the consumer must capture `res_addr` and `res_err` in that cycle. One shared sequential shift-add multiplier does all the products. A request therefore takes a few tens of cycles.

Top module: `addr_block_calc`

## Requirements
- R1: When bit 6 (mask 0x40) of the drive/head byte is set, the block number is {drive/head[3:0], cylinder-high, cylinder-low, sector}, with drive/head in bits 27:24 and sector in bits 7:0. The result is that block number times the block size.
- R2: When bit 6 of the drive/head byte is clear, the block number is ((cylinder × heads + head) × sectors + sector − 1). Here cylinder = {cylinder-high, cylinder-low} and head = drive/head[3:0]. The result is that block number times the block size.
- R3: Bit 4 (mask 0x10) of the drive/head byte selects the geometry of drive 1 when set and of drive 0 when clear. Drive d's fields sit at bits [d*W +: W] of each configuration vector.
- R4: A configured block size of 0 is treated as 512 bytes.
- R5: In cylinder/head/sector mode, a head count of 0, a head count above 16, or a sector count of 0 gives a result pulse with `res_err` = 1 and `res_addr` = 0.
- R6: In cylinder/head/sector mode, a sector byte of 0 gives an error result.
- R7: In either mode, a configured block size above 4096 gives an error result.
- R8: `res_valid` lasts exactly one cycle per accepted request, and `res_err` is high only together with `res_valid`.
- R9: `req_ready` is low from the edge after an acceptance until the result pulse. A request presented while `req_ready` is low produces no result.
- R10: The largest linear block number, 0xFFFFFFF, times 4096 gives 0xFFFFFFF000 without loss.
- R11: After reset, `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_dh | input | 8 | Drive/head register byte |
| req_cyl_hi | input | 8 | Cylinder high byte |
| req_cyl_lo | input | 8 | Cylinder low byte |
| req_sector | input | 8 | Sector number byte |
| cfg_heads | input | 10 | Head count per drive, 5 bits each |
| cfg_sectors | input | 16 | Sectors per track per drive, 8 bits each |
| cfg_bytes | input | 26 | Bytes per block per drive, 13 bits each, 0 means 512 |
| res_valid | output | 1 | One-cycle result pulse |
| res_err | output | 1 | Result is an error, qualified by res_valid |
| res_addr | output | 40 | Byte address, 0 on error |

## Verification
A sequencer stuck in a multiply state would show as `req_ready` staying low and no result pulse ever arriving. The directed requests detect this within their per-request wait of a few hundred cycles. A wrong operand or a skipped step shows up in `res_addr` on the very pulse of that request, and each geometry and mode case is chosen so that its expected value differs from the neighbouring cases. A mis-latched error flag or a stretched pulse is visible in the cycle of the pulse or the cycle after it.

// File: rtl/addr_calc_pkg.sv
package addr_calc_pkg;
  localparam int DRIVES = 2;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_HD,
    ST_MUL_SC,
    ST_MUL_BY,
    ST_FIN
  } calc_st_e;
endpackage

// File: rtl/addr_seq_mul.sv
module addr_seq_mul #(
  parameter int A_W = 28,
  parameter int B_W = 13,
  localparam int P_W = A_W + B_W,
  localparam int CNT_W = $clog2(B_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           done,
  output logic [P_W-1:0] prod
);
  logic [P_W-1:0]   acc, a_sh;
  logic [B_W-1:0]   b_sh;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      a_sh <= '0;
      b_sh <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        acc  <= '0;
        a_sh <= P_W'(a);
        b_sh <= b;
        cnt  <= CNT_W'(B_W);
        busy <= 1'b1;
      end else if (busy) begin
        if (b_sh[0]) acc <= acc + a_sh;
        a_sh <= a_sh << 1;
        b_sh <= b_sh >> 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
endmodule

// File: rtl/addr_req_decode.sv
module addr_req_decode #(
  parameter int HEADS_W   = 5,
  parameter int SECT_W    = 8,
  parameter int BYTES_W   = 13,
  parameter int BLK_W     = 28,
  parameter int MAX_HEADS = 16,
  parameter int MAX_BYTES = 4096,
  parameter int DEF_BYTES = 512,
  parameter int DRIVES    = 2
) (
  input  logic [7:0]                req_dh,
  input  logic [7:0]                req_cyl_hi,
  input  logic [7:0]                req_cyl_lo,
  input  logic [7:0]                req_sector,
  input  logic [DRIVES*HEADS_W-1:0] cfg_heads,
  input  logic [DRIVES*SECT_W-1:0]  cfg_sectors,
  input  logic [DRIVES*BYTES_W-1:0] cfg_bytes,
  output logic                      lba_mode,
  output logic [BLK_W-1:0]          lba_blk,
  output logic [15:0]               cyl,
  output logic [3:0]                head,
  output logic [HEADS_W-1:0]        heads_sel,
  output logic [SECT_W-1:0]         sects_sel,
  output logic [BYTES_W-1:0]        bytes_eff,
  output logic                      geo_err
);
  logic                 drv;
  logic [BYTES_W-1:0]   bytes_raw;

  assign drv       = req_dh[4];
  assign lba_mode  = req_dh[6];
  assign lba_blk   = BLK_W'({req_dh[3:0], req_cyl_hi, req_cyl_lo, req_sector});
  assign cyl       = {req_cyl_hi, req_cyl_lo};
  assign head      = req_dh[3:0];
  assign heads_sel = cfg_heads[drv*HEADS_W +: HEADS_W];
  assign sects_sel = cfg_sectors[drv*SECT_W +: SECT_W];
  assign bytes_raw = cfg_bytes[drv*BYTES_W +: BYTES_W];
  assign bytes_eff = (bytes_raw == '0) ? BYTES_W'(DEF_BYTES) : bytes_raw;

  always_comb begin
    geo_err = (bytes_raw > BYTES_W'(MAX_BYTES));
    if (!lba_mode) begin
      if (heads_sel == '0 || heads_sel > HEADS_W'(MAX_HEADS)) geo_err = 1'b1;
      if (sects_sel == '0) geo_err = 1'b1;
      if (req_sector == '0) geo_err = 1'b1;
    end
  end
endmodule

// File: rtl/addr_block_calc.sv
module addr_block_calc
  import addr_calc_pkg::*;
#(
  parameter int HEADS_W   = 5,
  parameter int SECT_W    = 8,
  parameter int BYTES_W   = 13,
  parameter int BLK_W     = 28,
  parameter int ADDR_W    = 40,
  parameter int MAX_HEADS = 16,
  parameter int MAX_BYTES = 4096,
  parameter int DEF_BYTES = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [7:0]                req_dh,
  input  logic [7:0]                req_cyl_hi,
  input  logic [7:0]                req_cyl_lo,
  input  logic [7:0]                req_sector,
  input  logic [DRIVES*HEADS_W-1:0] cfg_heads,
  input  logic [DRIVES*SECT_W-1:0]  cfg_sectors,
  input  logic [DRIVES*BYTES_W-1:0] cfg_bytes,
  output logic                      res_valid,
  output logic                      res_err,
  output logic [ADDR_W-1:0]         res_addr
);
  localparam int P_W = BLK_W + BYTES_W;

  logic               lba_mode, geo_err;
  logic [BLK_W-1:0]   lba_blk;
  logic [15:0]        cyl;
  logic [3:0]         head;
  logic [HEADS_W-1:0] heads_sel;
  logic [SECT_W-1:0]  sects_sel;
  logic [BYTES_W-1:0] bytes_eff;

  addr_req_decode #(
    .HEADS_W(HEADS_W), .SECT_W(SECT_W), .BYTES_W(BYTES_W), .BLK_W(BLK_W),
    .MAX_HEADS(MAX_HEADS), .MAX_BYTES(MAX_BYTES), .DEF_BYTES(DEF_BYTES),
    .DRIVES(DRIVES)
  ) u_dec (
    .req_dh(req_dh), .req_cyl_hi(req_cyl_hi), .req_cyl_lo(req_cyl_lo),
    .req_sector(req_sector), .cfg_heads(cfg_heads), .cfg_sectors(cfg_sectors),
    .cfg_bytes(cfg_bytes), .lba_mode(lba_mode), .lba_blk(lba_blk), .cyl(cyl),
    .head(head), .heads_sel(heads_sel), .sects_sel(sects_sel),
    .bytes_eff(bytes_eff), .geo_err(geo_err)
  );

  calc_st_e           st;
  logic               mul_go, mul_done, err_q;
  logic [BLK_W-1:0]   op_a;
  logic [BYTES_W-1:0] op_b;
  logic [P_W-1:0]     prod;
  logic [3:0]         head_q;
  logic [SECT_W-1:0]  sects_q;
  logic [7:0]         sec_q;
  logic [BYTES_W-1:0] bytes_q;
  logic [ADDR_W-1:0]  addr_q;

  addr_seq_mul #(.A_W(BLK_W), .B_W(BYTES_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .a(op_a), .b(op_b),
    .done(mul_done), .prod(prod)
  );

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      mul_go    <= 1'b0;
      err_q     <= 1'b0;
      op_a      <= '0;
      op_b      <= '0;
      head_q    <= '0;
      sects_q   <= '0;
      sec_q     <= '0;
      bytes_q   <= '0;
      addr_q    <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_addr  <= '0;
    end else begin
      mul_go    <= 1'b0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          head_q  <= head;
          sects_q <= sects_sel;
          sec_q   <= req_sector;
          bytes_q <= bytes_eff;
          err_q   <= geo_err;
          if (geo_err) begin
            st <= ST_FIN;
          end else if (lba_mode) begin
            op_a   <= lba_blk;
            op_b   <= bytes_eff;
            mul_go <= 1'b1;
            st     <= ST_MUL_BY;
          end else begin
            op_a   <= BLK_W'(cyl);
            op_b   <= BYTES_W'(heads_sel);
            mul_go <= 1'b1;
            st     <= ST_MUL_HD;
          end
        end
        ST_MUL_HD: if (mul_done) begin
          op_a   <= prod[BLK_W-1:0] + BLK_W'(head_q);
          op_b   <= BYTES_W'(sects_q);
          mul_go <= 1'b1;
          st     <= ST_MUL_SC;
        end
        ST_MUL_SC: if (mul_done) begin
          op_a   <= prod[BLK_W-1:0] + BLK_W'(sec_q) - BLK_W'(1);
          op_b   <= bytes_q;
          mul_go <= 1'b1;
          st     <= ST_MUL_BY;
        end
        ST_MUL_BY: if (mul_done) begin
          addr_q <= prod[ADDR_W-1:0];
          st     <= ST_FIN;
        end
        ST_FIN: begin
          res_valid <= 1'b1;
          res_err   <= err_q;
          res_addr  <= err_q ? '0 : addr_q;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_calc_chk.sv
module addr_calc_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_err,
  input logic [ADDR_W-1:0] res_addr
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> res_valid); // R8
  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_addr == '0)); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9
  AST_IDLE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready); // R9
endmodule

bind addr_block_calc addr_calc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_err(res_err), .res_addr(res_addr)
);

// File: tb/addr_block_calc_bench.sv
`timescale 1ns/1ps
module addr_block_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_dh = '0, req_cyl_hi = '0, req_cyl_lo = '0, req_sector = '0;
  logic [4:0]  h0 = '0, h1 = '0;
  logic [7:0]  s0 = '0, s1 = '0;
  logic [12:0] b0 = '0, b1 = '0;
  logic        res_valid, res_err;
  logic [39:0] res_addr;
  int          n_chk = 0, n_bad = 0;
  logic [39:0] got_addr;
  logic        got_err;

  always #4 clk = ~clk;

  addr_block_calc u_addr_block_calc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dh(req_dh), .req_cyl_hi(req_cyl_hi), .req_cyl_lo(req_cyl_lo),
    .req_sector(req_sector), .cfg_heads({h1, h0}), .cfg_sectors({s1, s0}),
    .cfg_bytes({b1, b0}), .res_valid(res_valid), .res_err(res_err),
    .res_addr(res_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Issue one request, wait for the result pulse, check pulse width (R8).
  task automatic run_req(input logic [7:0] dh, ch, cl, sn);
    int waited = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_dh = dh; req_cyl_hi = ch; req_cyl_lo = cl; req_sector = sn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", req_ready, 0);
    while (!res_valid && waited < 300) begin
      chk("R8 err only with valid", res_err, 0);
      @(negedge clk);
      waited++;
    end
    chk("R8 result arrives", res_valid, 1);
    got_addr = res_addr;
    got_err  = res_err;
    @(negedge clk);
    chk("R8 one-cycle pulse", res_valid, 0);
  endtask

  function automatic logic [63:0] chs_exp(input logic [15:0] c, input logic [3:0] hd,
      input logic [7:0] sn, input int heads, input int secs, input int bytes);
    logic [63:0] blk;
    blk = ((64'(c) * heads + hd) * secs) + sn - 1;
    return blk * bytes;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R11 ready after reset", req_ready, 1);
    chk("R11 no result after reset", res_valid, 0);
  endtask

  task automatic t_lba();
    b0 = 13'd512;
    run_req(8'h45, 8'h12, 8'h34, 8'h56);
    chk("R1 lba address", got_addr, 64'h5123456 * 512);
    chk("R1 lba no error", got_err, 0);
    b0 = 13'd2048;
    run_req(8'h40, 8'h00, 8'h00, 8'h07);
    chk("R1 lba small block", got_addr, 64'd7 * 2048);
  endtask

  task automatic t_default_bytes();
    b0 = 13'd0;
    run_req(8'h41, 8'h00, 8'h10, 8'h03);
    chk("R4 default 512", got_addr, 64'h1001003 * 512);
  endtask

  task automatic t_chs();
    h1 = 5'd16; s1 = 8'd63; b1 = 13'd1024;
    h0 = 5'd4;  s0 = 8'd32; b0 = 13'd512;
    run_req(8'h1A, 8'h01, 8'h2C, 8'h07);
    chk("R2 chs drive1", got_addr, chs_exp(16'h012C, 4'hA, 8'h07, 16, 63, 1024));
    chk("R2 chs no error", got_err, 0);
    run_req(8'h03, 8'h01, 8'h2C, 8'h07);
    chk("R3 drive0 geometry", got_addr, chs_exp(16'h012C, 4'h3, 8'h07, 4, 32, 512));
    run_req(8'h00, 8'h00, 8'h00, 8'h01);
    chk("R2 first sector is zero", got_addr, 0);
    chk("R2 first sector no error", got_err, 0);
  endtask

  task automatic t_chs_bad_geo();
    h0 = 5'd0; s0 = 8'd32;
    run_req(8'h00, 8'h00, 8'h05, 8'h01);
    chk("R5 zero heads err", got_err, 1);
    chk("R5 zero heads addr", got_addr, 0);
    h0 = 5'd4; s0 = 8'd0;
    run_req(8'h00, 8'h00, 8'h05, 8'h01);
    chk("R5 zero sectors err", got_err, 1);
    h0 = 5'd17; s0 = 8'd32;
    run_req(8'h00, 8'h00, 8'h05, 8'h01);
    chk("R5 heads above 16 err", got_err, 1);
    // zero heads does not matter in linear mode
    h0 = 5'd0; s0 = 8'd0; b0 = 13'd512;
    run_req(8'h40, 8'h00, 8'h00, 8'h02);
    chk("R5 lba ignores geometry", got_err, 0);
    chk("R5 lba addr", got_addr, 64'd1024);
  endtask

  task automatic t_sector_zero();
    h0 = 5'd4; s0 = 8'd32; b0 = 13'd512;
    run_req(8'h02, 8'h00, 8'h09, 8'h00);
    chk("R6 sector zero err", got_err, 1);
    chk("R6 sector zero addr", got_addr, 0);
  endtask

  task automatic t_big_block();
    b0 = 13'd4097;
    run_req(8'h40, 8'h00, 8'h00, 8'h01);
    chk("R7 lba block too big", got_err, 1);
    h0 = 5'd4; s0 = 8'd32;
    run_req(8'h00, 8'h00, 8'h00, 8'h01);
    chk("R7 chs block too big", got_err, 1);
    b0 = 13'd4096;
    run_req(8'h4F, 8'hFF, 8'hFF, 8'hFF);
    chk("R10 max address", got_addr, 64'hFFFFFFF000);
    chk("R10 max no error", got_err, 0);
  endtask

  task automatic t_ignore_busy();
    int seen = 0;
    b0 = 13'd512;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_dh = 8'h40; req_cyl_hi = 8'h00; req_cyl_lo = 8'h00; req_sector = 8'h05;
    req_valid = 1'b1;
    @(negedge clk);
    req_dh = 8'h40; req_sector = 8'h09;
    for (int i = 0; i < 5; i++) begin
      chk("R9 ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 300 && !res_valid; i++) @(negedge clk);
    chk("R9 first request served", res_addr, 64'd5 * 512);
    @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      if (res_valid) seen++;
      @(negedge clk);
    end
    chk("R9 busy request dropped", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lba();
    t_default_bytes();
    t_chs();
    t_chs_bad_geo();
    t_sector_zero();
    t_big_block();
    t_ignore_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule